// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked model of a retriggerable monostable. Three level inputs are sampled on the system clock, and each input is compared with its sample from the previous clock to find edges. When one of three qualified edge conditions is seen, the block starts a pulse. The pulse has a discharge phase and then a charge phase, and the output stays high through both. The length of each phase comes from a programmable input. Counters take the place of the analog resistor-capacitor timing.

A qualified trigger seen during the charge phase sends the block back to the discharge phase, so the pulse is stretched. A trigger seen during the discharge phase is dropped. An active-low clear ends any pulse and blocks all triggers while it is held low. The rising edge of the clear is also one of the three trigger conditions. The inputs are assumed to be already synchronous to the clock.

Top module: `retrig_pulse_gen`

## Requirements
- R1: While and after synchronous reset `rst`, with no trigger applied, `pulseOut` is 0 and `pulseOutN` is 1. Reset takes the previous-sample registers to `fallTrig`=1, `riseTrig`=0, `clearN`=1.
- R2: `riseTrig` going from 0 to 1 while `fallTrig` is 0 and `clearN` is 1 is a trigger.
- R3: `fallTrig` going from 1 to 0 while `riseTrig` is 1 and `clearN` is 1 is a trigger.
- R4: `clearN` going from 0 to 1 while `fallTrig` is 0 and `riseTrig` is 1 is a trigger.
- R5: Any other input change starts no pulse, for example `riseTrig` rising while `fallTrig` is 1, or `fallTrig` falling while `riseTrig` is 0.
- R6: An isolated trigger gives a pulse exactly D+W cycles long. D and W are `dischargeLen` and `chargeLen` as sampled on the clock edge that sees the trigger.
- R7: A trigger seen while the block is in its charge phase restarts the discharge phase. The pulse then ends D+W cycles after that trigger's own rise point.
- R8: A trigger seen while the block is in its discharge phase has no effect, and the pulse ends at its original time.
- R9: `clearN` sampled low drives `pulseOut` low from that clock edge on. While `clearN` stays low, no trigger starts a pulse.
- R10: `pulseOutN` is always the complement of `pulseOut`.
- R11: A length input of zero counts as one cycle, so D=0 and W=0 give a 2-cycle pulse.
- R12: The edge that sees a trigger captures it, and `pulseOut` rises on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fallTrig | input | 1 | Trigger input that fires on its falling edge |
| riseTrig | input | 1 | Trigger input that fires on its rising edge |
| clearN | input | 1 | Active-low clear; its rising edge can also trigger |
| dischargeLen | input | CNT_W | Discharge phase length in cycles (0 counts as 1) |
| chargeLen | input | CNT_W | Charge phase length in cycles (0 counts as 1) |
| pulseOut | output | 1 | One-shot output |
| pulseOutN | output | 1 | Complement of pulseOut |

## Verification
Suppose an input edge is driven just before clock edge k. The trigger is captured at edge k, and `pulseOut` goes high at edge k+1. It then stays high for D+W edges, so it is high at the half-cycle points m+2 through m+1+D+W, where m is the drive point. A clear sampled low ends the pulse at the very next edge.

The bench drives inputs on the falling clock edge and reads outputs on the following falling edge. Each scenario counts the high half-cycle samples in a fixed window and compares that count with the value worked out from these latencies. A behavioural model advances on every rising edge and is compared with both outputs at every falling edge.

// File: rtl/retrig_pkg.sv
package retrig_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIS  = 2'd1,
    PH_CHG  = 2'd2
  } phase_e;

  // Strobes from the controller to the timing datapath
  typedef struct packed {
    logic loadDis;   // load discharge length, latch charge length
    logic loadChg;   // load the latched charge length
    logic decr;      // count down by one
    logic clr;       // clear the counter
  } ctrl_strobe_t;

endpackage

// File: rtl/retrig_datapath.sv
module retrig_datapath
  import retrig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fallTrig,
  input  logic             riseTrig,
  input  logic             clearN,
  input  logic [CNT_W-1:0] dischargeLen,
  input  logic [CNT_W-1:0] chargeLen,
  input  ctrl_strobe_t     strobe,
  output logic             trigSeen,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             fallPrev, risePrev, clrPrev;
  logic             condRise, condFall, condClr, qualTrig;
  logic [CNT_W-1:0] pendDis, pendChg, chgHold, cnt;

  // Reload value for a requested length (zero counts as one cycle)
  function automatic logic [CNT_W-1:0] reloadOf(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - ONE;
  endfunction

  // Qualified trigger conditions against the previous samples
  always_comb begin
    condRise = riseTrig & ~risePrev & ~fallTrig;
    condFall = ~fallTrig & fallPrev & riseTrig;
    condClr  = clearN & ~clrPrev & ~fallTrig & riseTrig;
    qualTrig = clearN & (condRise | condFall | condClr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fallPrev <= 1'b1;
      risePrev <= 1'b0;
      clrPrev  <= 1'b1;
      trigSeen <= 1'b0;
      pendDis  <= '0;
      pendChg  <= '0;
    end else begin
      fallPrev <= fallTrig;
      risePrev <= riseTrig;
      clrPrev  <= clearN;
      trigSeen <= qualTrig;
      if (qualTrig) begin
        pendDis <= dischargeLen;
        pendChg <= chargeLen;
      end
    end
  end

  // Phase counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      chgHold <= '0;
    end else if (strobe.clr) begin
      cnt <= '0;
    end else if (strobe.loadDis) begin
      cnt     <= reloadOf(pendDis);
      chgHold <= pendChg;
    end else if (strobe.loadChg) begin
      cnt <= reloadOf(chgHold);
    end else if (strobe.decr) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/retrig_ctrl.sv
module retrig_ctrl
  import retrig_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         clearN,
  input  logic         trigSeen,
  input  logic         cntZero,
  output ctrl_strobe_t strobe,
  output phase_e       phase,
  output logic         busy
);

  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (!clearN) begin
      phaseNext  = PH_IDLE;
      strobe.clr = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (trigSeen) begin
            phaseNext      = PH_DIS;
            strobe.loadDis = 1'b1;
          end
        end
        PH_DIS: begin
          // triggers are dropped while discharging
          if (cntZero) begin
            phaseNext      = PH_CHG;
            strobe.loadChg = 1'b1;
          end else begin
            strobe.decr = 1'b1;
          end
        end
        PH_CHG: begin
          if (trigSeen) begin
            phaseNext      = PH_DIS;
            strobe.loadDis = 1'b1;
          end else if (cntZero) begin
            phaseNext  = PH_IDLE;
            strobe.clr = 1'b1;
          end else begin
            strobe.decr = 1'b1;
          end
        end
        default: begin
          phaseNext  = PH_IDLE;
          strobe.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/retrig_pulse_gen.sv
module retrig_pulse_gen
  import retrig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fallTrig,
  input  logic             riseTrig,
  input  logic             clearN,
  input  logic [CNT_W-1:0] dischargeLen,
  input  logic [CNT_W-1:0] chargeLen,
  output logic             pulseOut,
  output logic             pulseOutN
);

  ctrl_strobe_t strobe;
  phase_e       phase;
  logic         trigSeen, cntZero, busy;

  retrig_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .fallTrig(fallTrig), .riseTrig(riseTrig),
    .clearN(clearN), .dischargeLen(dischargeLen), .chargeLen(chargeLen),
    .strobe(strobe), .trigSeen(trigSeen), .cntZero(cntZero)
  );

  retrig_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clearN(clearN), .trigSeen(trigSeen),
    .cntZero(cntZero), .strobe(strobe), .phase(phase), .busy(busy)
  );

  assign pulseOut  = busy;
  assign pulseOutN = ~busy;

endmodule

// File: rtl/retrig_pulse_checker.sv
module retrig_pulse_checker
  import retrig_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   clearN,
  input logic   pulseOut,
  input logic   pulseOutN,
  input logic   trigSeen,
  input logic   cntZero,
  input phase_e phase
);

  p_complement_r10: assert property (@(posedge clk) disable iff (rst)
    pulseOutN == ~pulseOut);

  p_clear_low_r9: assert property (@(posedge clk) disable iff (rst)
    !clearN |=> !pulseOut);

  p_rise_after_capture_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOut) |-> $past(trigSeen));

  p_retrigger_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHG && trigSeen && clearN) |=> phase == PH_DIS);

  p_discharge_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DIS && !cntZero && clearN) |=> phase == PH_DIS);

  p_idle_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !trigSeen) |=> phase == PH_IDLE);

endmodule

bind retrig_pulse_gen retrig_pulse_checker u_chk (
  .clk(clk), .rst(rst), .clearN(clearN), .pulseOut(pulseOut),
  .pulseOutN(pulseOutN), .trigSeen(trigSeen), .cntZero(cntZero),
  .phase(phase)
);

// File: tb/retrig_pulse_gen_bench.sv
module retrig_pulse_gen_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fallTrig = 1'b1, riseTrig = 1'b0, clearN = 1'b1;
  logic [CW-1:0] disLen = '0, chgLen = '0;
  logic          pulseOut, pulseOutN;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  retrig_pulse_gen #(.CNT_W(CW)) u_retrig_pulse_gen (
    .clk(clk), .rst(rst), .fallTrig(fallTrig), .riseTrig(riseTrig),
    .clearN(clearN), .dischargeLen(disLen), .chargeLen(chgLen),
    .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

  // Behavioural reference model
  int  mPhase = 0, mLeft = 0, mChg = 0, mPendD = 0, mPendC = 0;
  bit  mPend = 0, mPa = 1, mPb = 0, mPc = 1;

  always @(posedge clk) begin
    bit det;
    cycles++;
    if (rst) begin
      mPhase = 0; mLeft = 0; mPend = 0; mPa = 1; mPb = 0; mPc = 1;
    end else begin
      det = clearN && ((riseTrig && !mPb && !fallTrig) ||
                       (!fallTrig && mPa && riseTrig) ||
                       (clearN && !mPc && !fallTrig && riseTrig));
      if (!clearN) mPhase = 0;
      else if (mPend && mPhase != 1) begin
        mPhase = 1;
        mLeft  = (mPendD == 0) ? 1 : mPendD;
        mChg   = (mPendC == 0) ? 1 : mPendC;
      end else if (mPhase == 1) begin
        mLeft--;
        if (mLeft == 0) begin mPhase = 2; mLeft = mChg; end
      end else if (mPhase == 2) begin
        mLeft--;
        if (mLeft == 0) mPhase = 0;
      end
      mPend = det;
      if (det) begin mPendD = int'(disLen); mPendC = int'(chgLen); end
      mPa = fallTrig; mPb = riseTrig; mPc = clearN;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pulseOut !== (mPhase != 0)) begin
        errors++;
        $display("FAIL R6 model: actual=%0b expected=%0b", pulseOut, mPhase != 0);
      end
      checks++;
      if (pulseOutN !== ~pulseOut) begin
        errors++;
        $display("FAIL R10 complement: actual=%0b expected=%0b", pulseOutN, ~pulseOut);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    check("R1 reset out", int'(pulseOut), 0);
    check("R1 reset outN", int'(pulseOutN), 1);
    rst = 1'b0;
    idle(3);
    check("R1 after reset", int'(pulseOut), 0);

    // R2 + R12 + R6: riseTrig rises with fallTrig low
    disLen = 3; chgLen = 5;
    fallTrig = 1'b0;              // fall with riseTrig low: no trigger
    idle(4);
    check("R5 fall with rise low", int'(pulseOut), 0);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == 1) check("R12 low one edge after", int'(pulseOut), 0);
      if (i == 2) check("R12 high two edges after", int'(pulseOut), 1);
      highs += int'(pulseOut);
    end
    check("R2/R6 width", highs, 8);

    // R3: fallTrig falls with riseTrig high
    fallTrig = 1'b1; idle(2);
    disLen = 2; chgLen = 7;
    fallTrig = 1'b0; highs = 0;
    for (int i = 1; i <= 14; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R3 width", highs, 9);

    // R4: clearN rises with fallTrig low, riseTrig high
    clearN = 1'b0; idle(2);
    check("R9 held by clear", int'(pulseOut), 0);
    disLen = 4; chgLen = 4;
    clearN = 1'b1; highs = 0;
    for (int i = 1; i <= 12; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R4 width", highs, 8);

    // R5: riseTrig rises while fallTrig high
    riseTrig = 1'b0; fallTrig = 1'b1; idle(2);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 10; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R5 no pulse", highs, 0);

    // R11: zero lengths
    riseTrig = 1'b0; fallTrig = 1'b0; disLen = 0; chgLen = 0; idle(2);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 8; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R11 zero lengths", highs, 2);

    // R7: retrigger in charge phase
    riseTrig = 1'b0; disLen = 2; chgLen = 10; idle(2);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk); highs += int'(pulseOut);
      if (i == 4) riseTrig = 1'b0;
      if (i == 6) riseTrig = 1'b1;
    end
    check("R7 extended width", highs, 18);

    // R8: retrigger in discharge phase
    riseTrig = 1'b0; disLen = 6; chgLen = 4; idle(2);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk); highs += int'(pulseOut);
      if (i == 2) riseTrig = 1'b0;
      if (i == 3) riseTrig = 1'b1;
    end
    check("R8 width unchanged", highs, 10);

    // R9: clear ends a pulse and blocks triggers
    riseTrig = 1'b0; disLen = 2; chgLen = 20; idle(2);
    riseTrig = 1'b1; highs = 0;
    for (int i = 1; i <= 5; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R9 before clear", highs, 4);
    clearN = 1'b0;
    @(negedge clk);
    check("R9 low next edge", int'(pulseOut), 0);
    highs = 0;
    for (int i = 1; i <= 12; i++) begin
      riseTrig = (i % 2 == 0);
      @(negedge clk); highs += int'(pulseOut);
    end
    check("R9 triggers ignored", highs, 0);
    riseTrig = 1'b0; @(negedge clk);
    clearN = 1'b1; highs = 0;
    for (int i = 1; i <= 6; i++) begin @(negedge clk); highs += int'(pulseOut); end
    check("R9 release without trigger", highs, 0);

    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule